// File: doc/BRIEF.md
# Power-Good / Power-Down Sequencer

This block watches one active-low control pin whose meaning changes over time. After a power-on reset the pin only qualifies power: while it has never been seen high, the clock outputs stay disabled while the serial slave and the core (oscillator) enable stay on. The first debounced high sample arms the block. From then on, until the next power-on reset, the same pin is a power-down request.

When the block is armed, a low level on the pin is captured asynchronously. It forces the global output-disable high and drops the serial-interface enable and the core enable in the same instant, with no clock edge needed. The capture is sticky, so a pin pulse shorter than a clock period still results in a full power-down. Leaving power-down needs a synchronized, debounced rising edge. The outputs come back on a reference clock edge a fixed number of cycles after the pin rises. The output-disable feeds the clock gates, and the two enables feed the serial slave and the oscillator control.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: From power-on reset until the first qualified high, outDisable is 1 and serialEn and coreEn are both 1, whatever level the pin has.
- R2: A pin high held in the waiting phase enables outputs: outDisable falls after exactly SYNC_STAGES+DEB_SAMPLES rising clock edges counted from the pin change (4 with defaults), and serialEn and coreEn stay 1.
- R3: While armed, a low pin sets outDisable to 1 and clears serialEn and coreEn at once, before any clock edge.
- R4: While armed and the pin stays low, outDisable stays 1 and serialEn and coreEn stay 0 on every cycle.
- R5: After the pin rises in power-down, all three outputs keep their power-down values until the SYNC_STAGES+DEB_SAMPLES-th rising edge (4 with defaults, inside the 2 to 6 cycle window). On that edge outDisable becomes 0 and serialEn and coreEn become 1. This holds for any low duration of one cycle or more.
- R6: In power-down, a pin high lasting fewer than DEB_SAMPLES cycles releases nothing.
- R7: The armed mode survives every power-down and release. Only porN low returns the block to the waiting phase of R1, and it does so asynchronously.
- R8: In the waiting phase, a pin high lasting fewer than DEB_SAMPLES cycles does not arm the block, so a later low pin leaves serialEn at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| pwrPin | input | 1 | Dual-role pin: power-good before arming, active-low power-down request after |
| outDisable | output | 1 | Global disable to the output clock gates (1 = outputs held low) |
| serialEn | output | 1 | Enable for the serial slave |
| coreEn | output | 1 | Enable for the core oscillator |

## Verification
The bench builds the block with the defaults of two synchronizer stages and two debounce samples, so the release latency works out to four reference edges. Every edge of the entry and exit windows can be checked one by one. A sweep of power-down lengths from one to eight cycles covers the case where the pin returns high before the synchronizer has seen it low, as well as the settled case. One-cycle high pulses, in the waiting phase and in power-down, sit just below the debounce threshold and test it.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_RUN  = 2'd1,
    ST_DOWN = 2'd2
  } pwrStateT;

  // Strobes from the sequencer to the pin filter.
  typedef struct packed {
    logic clrHold;     // drop the captured power-down flag
    logic restartDeb;  // zero the consecutive-high counter
  } holdCtlT;

  // Mode strobes from the sequencer to the output gating.
  typedef struct packed {
    logic armed;       // pin has been qualified high since reset
    logic run;         // outputs may toggle
    logic powerDown;   // sequencer sits in power-down
  } modeT;

endpackage

// File: rtl/pwr_seq_filter.sv
module pwr_seq_filter
  import pwr_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_SAMPLES = 2
) (
  input  logic    clk,
  input  logic    porN,
  input  logic    pwrPin,
  input  holdCtlT holdCtl,
  output logic    highOk,
  output logic    pdHold
);

  localparam int CNT_W = (DEB_SAMPLES < 2) ? 1 : $clog2(DEB_SAMPLES + 1);
  localparam logic [CNT_W-1:0] CNT_TGT = CNT_W'(DEB_SAMPLES - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   pinSync;
  logic [CNT_W-1:0]       highCnt;

  // Synchronizer chain for the pin.
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge porN) begin
        if (!porN) syncQ <= '0;
        else       syncQ <= pwrPin;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge porN) begin
        if (!porN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], pwrPin};
      end
    end
  endgenerate

  assign pinSync = syncQ[SYNC_STAGES-1];

  // Count consecutive synchronized high samples, saturating at the target.
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      highCnt <= '0;
    end else if (holdCtl.restartDeb || !pinSync) begin
      highCnt <= '0;
    end else if (highCnt != CNT_TGT) begin
      highCnt <= highCnt + 1'b1;
    end
  end

  assign highOk = pinSync && (highCnt == CNT_TGT);

  // Power-down capture: set by the pin level itself, cleared only on request.
  always_ff @(posedge clk or negedge porN or negedge pwrPin) begin
    if (!porN || !pwrPin) pdHold <= 1'b1;
    else if (holdCtl.clrHold) pdHold <= 1'b0;
  end

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
(
  input  logic    clk,
  input  logic    porN,
  input  logic    highOk,
  input  logic    pdHold,
  output holdCtlT holdCtl,
  output modeT    mode
);

  pwrStateT stateQ, stateNxt;

  always_comb begin
    stateNxt = stateQ;
    unique case (stateQ)
      ST_WAIT: if (highOk) stateNxt = ST_RUN;
      ST_RUN:  if (pdHold) stateNxt = ST_DOWN;
      ST_DOWN: if (highOk) stateNxt = ST_RUN;
      default: stateNxt = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) stateQ <= ST_WAIT;
    else       stateQ <= stateNxt;
  end

  always_comb begin
    holdCtl.clrHold    = (stateQ == ST_WAIT) || ((stateQ == ST_DOWN) && highOk);
    holdCtl.restartDeb = (stateQ == ST_RUN) && pdHold;
    mode.armed         = (stateQ != ST_WAIT);
    mode.run           = (stateQ == ST_RUN);
    mode.powerDown     = (stateQ == ST_DOWN);
  end

endmodule

// File: rtl/pwr_seq_gate.sv
module pwr_seq_gate
  import pwr_seq_pkg::*;
(
  input  modeT mode,
  input  logic pdHold,
  output logic outDisable,
  output logic serialEn,
  output logic coreEn
);

  logic forceOff;

  // Captured request acts without waiting for the sequencer.
  assign forceOff   = mode.armed && pdHold;
  assign outDisable = !mode.run || forceOff;
  assign serialEn   = !(mode.powerDown || forceOff);
  assign coreEn     = !(mode.powerDown || forceOff);

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_SAMPLES = 2
) (
  input  logic clk,
  input  logic porN,
  input  logic pwrPin,
  output logic outDisable,
  output logic serialEn,
  output logic coreEn
);

  holdCtlT holdStrb;
  modeT    modeStrb;
  logic    highOk;
  logic    pdHold;

  pwr_seq_filter #(
    .SYNC_STAGES(SYNC_STAGES),
    .DEB_SAMPLES(DEB_SAMPLES)
  ) u_filter (
    .clk    (clk),
    .porN   (porN),
    .pwrPin (pwrPin),
    .holdCtl(holdStrb),
    .highOk (highOk),
    .pdHold (pdHold)
  );

  pwr_seq_fsm u_fsm (
    .clk    (clk),
    .porN   (porN),
    .highOk (highOk),
    .pdHold (pdHold),
    .holdCtl(holdStrb),
    .mode   (modeStrb)
  );

  pwr_seq_gate u_gate (
    .mode      (modeStrb),
    .pdHold    (pdHold),
    .outDisable(outDisable),
    .serialEn  (serialEn),
    .coreEn    (coreEn)
  );

endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk
  import pwr_seq_pkg::*;
(
  input logic clk,
  input logic porN,
  input logic pwrPin,
  input logic outDisable,
  input logic serialEn,
  input logic coreEn,
  input modeT mode,
  input logic highOk
);

  p_wait_open_r1: assert property (@(posedge clk) disable iff (!porN)
    !mode.armed |-> (outDisable && serialEn && coreEn));

  p_force_off_r3: assert property (@(posedge clk) disable iff (!porN)
    (mode.armed && !pwrPin) |-> (outDisable && !serialEn && !coreEn));

  p_down_hold_r4: assert property (@(posedge clk) disable iff (!porN)
    (mode.powerDown && !highOk) |=> !mode.run);

  p_rise_qual_r5: assert property (@(posedge clk) disable iff (!porN)
    $rose(mode.run) |-> $past(highOk));

  p_armed_sticky_r7: assert property (@(posedge clk) disable iff (!porN)
    mode.armed |=> mode.armed);

endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk u_chk (
  .clk       (clk),
  .porN      (porN),
  .pwrPin    (pwrPin),
  .outDisable(outDisable),
  .serialEn  (serialEn),
  .coreEn    (coreEn),
  .mode      (modeStrb),
  .highOk    (highOk)
);

// File: tb/pwr_seq_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_bench;

  localparam int SYNC = 2;
  localparam int DEB  = 2;
  localparam int LAT  = SYNC + DEB;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic pwrPin = 1'b0;
  logic outDisable, serialEn, coreEn;
  int   nChecks = 0;
  int   nFails  = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  pwr_seq_ctrl #(.SYNC_STAGES(SYNC), .DEB_SAMPLES(DEB)) u_pwr_seq_ctrl (
    .clk(clk), .porN(porN), .pwrPin(pwrPin),
    .outDisable(outDisable), .serialEn(serialEn), .coreEn(coreEn)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chkAll(input logic eDis, input logic eSer, input logic eCore, input string tag);
    chk(outDisable, eDis, {tag, " outDisable"});
    chk(serialEn, eSer, {tag, " serialEn"});
    chk(coreEn, eCore, {tag, " coreEn"});
  endtask

  // Edge k after a pin change; sampled mid-high phase.
  task automatic afterEdge();
    @(posedge clk); #5;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  // Release check: pin rises at a falling edge, outputs return on edge LAT.
  task automatic releaseRun(input string tag);
    @(negedge clk); pwrPin = 1'b1; #1;
    chkAll(1'b1, 1'b0, 1'b0, {tag, " at rise"});
    for (int k = 1; k <= LAT + 2; k++) begin
      afterEdge();
      if (k < LAT) chkAll(1'b1, 1'b0, 1'b0, {tag, " before release"});
      else         chkAll(1'b0, 1'b1, 1'b1, {tag, " released"});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chkAll(1'b1, 1'b1, 1'b1, "R1 in reset");
    porN = 1'b1;
    for (int k = 0; k < 6; k++) begin
      afterEdge();
      chkAll(1'b1, 1'b1, 1'b1, "R1 waiting pin low");
    end

    // R8: one-cycle high in the waiting phase
    @(negedge clk); pwrPin = 1'b1;
    @(negedge clk); pwrPin = 1'b0;
    for (int k = 0; k < 8; k++) begin
      afterEdge();
      chkAll(1'b1, 1'b1, 1'b1, "R8 short high ignored");
    end

    // R2: qualified high arms and enables after LAT edges
    @(negedge clk); pwrPin = 1'b1;
    for (int k = 1; k <= LAT + 2; k++) begin
      afterEdge();
      chk(outDisable, (k < LAT), "R2 arm latency");
      chk(serialEn, 1'b1, "R2 serial stays on");
    end
    chk(coreEn, 1'b1, "R2 core on");

    // R3/R4/R5/R7: sweep power-down length
    for (int len = 1; len <= 8; len++) begin
      @(negedge clk); pwrPin = 1'b0; #1;
      chkAll(1'b1, 1'b0, 1'b0, "R3 immediate force");
      for (int k = 0; k < len; k++) begin
        afterEdge();
        chkAll(1'b1, 1'b0, 1'b0, "R4 held in power-down");
      end
      releaseRun("R5 sweep");
      chk(serialEn, 1'b1, "R7 armed after release");
    end

    // R6: one-cycle high inside power-down
    @(negedge clk); pwrPin = 1'b0;
    repeat (3) @(negedge clk);
    pwrPin = 1'b1;
    @(negedge clk); pwrPin = 1'b0;
    for (int k = 0; k < 8; k++) begin
      afterEdge();
      chkAll(1'b1, 1'b0, 1'b0, "R6 short high no release");
    end
    releaseRun("R6 later release");

    // R7: power-on reset returns to the waiting phase
    @(negedge clk); porN = 1'b0; #1;
    chkAll(1'b1, 1'b1, 1'b1, "R7 por async");
    pwrPin = 1'b0;
    @(negedge clk); porN = 1'b1;
    for (int k = 0; k < 5; k++) begin
      afterEdge();
      chkAll(1'b1, 1'b1, 1'b1, "R7 unarmed after por");
    end
    @(negedge clk); pwrPin = 1'b1;
    for (int k = 1; k <= LAT + 1; k++) begin
      afterEdge();
      chk(outDisable, (k < LAT), "R7 re-arm latency");
    end

    done = 1'b1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

endmodule